// File: doc/BRIEF.md
# Kernel Stack Limit Guard

This block holds a programmable lower bound for the kernel stack and grades every new stack-pointer value against it. A bus master programs the bound through a single register word. The processor core presents each candidate stack pointer on an update strobe. The candidate comes either directly or as the result of a frame-unwind step, which the guard forms from a program counter and a 6-bit word count. The guard classifies the candidate as normal, warning (yellow) or fatal (red).

When the processor is in kernel mode and the candidate falls inside the fatal band, the guard overrides the stack pointer with a fixed safe value and requests a trap through a fixed vector. In the warning band it only emits a one-cycle warning pulse, and the update goes through. Outside kernel mode the candidate passes through untouched. The surrounding core owns the trap sequencer and the error bookkeeping. It also raises `bus_reset` when it executes its bus-reset instruction.

Top module: `stack_guard_top`

## Requirements
- R1: A read strobe at word address 0x3FFFC returns the current limit on `bus_rdata` one cycle later. A read at any other address, or no read, gives 0 there.
- R2: A write at 0x3FFFC stores `bus_wdata & 0xFF00`, so bits 7:0 of the limit are always 0. Writes to other addresses leave the limit unchanged.
- R3: When `cpu_mode` is not 0 (kernel), an update produces `sp_out` equal to the candidate, with `yellow_pulse` and `red_trap` both 0.
- R4: In kernel mode, a candidate below limit+224 gives, one cycle later, `red_trap`=1, `sp_out`=0x0004 and `trap_vector`=0x0004.
- R5: In kernel mode, a candidate at or above limit+224 and below limit+256 gives `yellow_pulse`=1 and `sp_out` equal to the candidate. A candidate at or above limit+256 raises no flag.
- R6: The comparisons are unsigned and use 17-bit bounds. With limit 0xFF00, the candidate 0xFFFF is yellow and does not wrap to normal.
- R7: `yellow_pulse` and `red_trap` are never both 1. Each lasts one cycle and appears only in the cycle after an update strobe. Outside that cycle `sp_out_valid`, `sp_out` and `trap_vector` are 0.
- R8: `bus_reset` clears the limit to 0, and it wins over a write in the same cycle.
- R9: A synchronous `rst` clears the limit and every output to 0.
- R10: `unwind_valid` forms the candidate as (`unwind_pc` + 2*`unwind_count`) modulo 2^16. When both strobes are high, the unwind candidate is used.
- R11: An update in the same cycle as a limit write is graded against the limit held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_reset | input | 1 | Bus-reset instruction pulse; clears the limit |
| bus_addr | input | 18 | Register bus word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cpu_mode | input | 2 | Current processor mode, 0 = kernel |
| sp_upd_valid | input | 1 | Direct stack-pointer update strobe |
| sp_upd_value | input | 16 | Direct candidate stack pointer |
| unwind_valid | input | 1 | Frame-unwind update strobe |
| unwind_pc | input | 16 | Program counter for the unwind sum |
| unwind_count | input | 6 | Word count for the unwind sum |
| sp_out_valid | output | 1 | Graded stack pointer is valid |
| sp_out | output | 16 | Stack pointer to commit (forced on red) |
| yellow_pulse | output | 1 | Warning-band pulse |
| red_trap | output | 1 | Fatal-band trap request |
| trap_vector | output | 16 | Trap vector while `red_trap` is high |

## Verification
The bench builds the guard with its default parameters: a 16-bit data path, 18-bit addresses, fatal and warning spans of 224 and 256, and 8 alignment bits. With these values, limits near 0xFF00 push the warning bound to exactly 0x10000, which exercises the 17-bit compare. The largest unwind count (63) gives the widest offset the sum can reach, and a program counter near 0xFFFF makes the unwind sum wrap. Directed edges at limit+223, +224, +255 and +256 are mixed with random traffic that switches mode and collides writes with updates.

// File: rtl/stack_guard_pkg.sv
package stack_guard_pkg;
  typedef enum logic [1:0] {
    ZONE_OK     = 2'd0,
    ZONE_YELLOW = 2'd1,
    ZONE_RED    = 2'd2
  } zone_e;
endpackage

// File: rtl/stack_guard_limit.sv
module stack_guard_limit #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter logic [AW-1:0] LIMIT_ADDR = 18'h3FFFC,
  parameter int ALIGN_BITS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_reset,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] limit
);
  localparam logic [DW-1:0] KEEP_MASK = {DW{1'b1}} << ALIGN_BITS;

  logic sel;
  assign sel = (addr == LIMIT_ADDR);

  always_ff @(posedge clk) begin
    if (rst || bus_reset) begin
      limit <= '0;
    end else if (wr && sel) begin
      limit <= wdata & KEEP_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= (rd && sel) ? limit : '0;
    end
  end

  a_r8_bus_reset_clears: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (limit == '0));
  a_r2_write_masked: assert property (@(posedge clk) disable iff (rst)
    (wr && sel && !bus_reset) |=> (limit == ($past(wdata) & KEEP_MASK)));
endmodule

// File: rtl/stack_guard_source.sv
module stack_guard_source #(
  parameter int DW = 16,
  parameter int CW = 6
) (
  input  logic          sp_upd_valid,
  input  logic [DW-1:0] sp_upd_value,
  input  logic          unwind_valid,
  input  logic [DW-1:0] unwind_pc,
  input  logic [CW-1:0] unwind_count,
  output logic          cand_valid,
  output logic [DW-1:0] cand
);
  logic [DW-1:0] unwind_sum;
  assign unwind_sum = unwind_pc + (DW'(unwind_count) << 1);

  always_comb begin
    cand_valid = sp_upd_valid || unwind_valid;
    cand       = unwind_valid ? unwind_sum : sp_upd_value;
  end
endmodule

// File: rtl/stack_guard_cmp.sv
module stack_guard_cmp
  import stack_guard_pkg::*;
#(
  parameter int DW = 16,
  parameter int RED_SPAN = 224,
  parameter int YELLOW_SPAN = 256
) (
  input  logic          check_en,
  input  logic [DW-1:0] cand,
  input  logic [DW-1:0] limit,
  output zone_e         zone
);
  localparam int BW = DW + 1;

  logic [BW-1:0] red_bound;
  logic [BW-1:0] yellow_bound;
  logic [BW-1:0] cand_w;

  assign red_bound    = {1'b0, limit} + BW'(RED_SPAN);
  assign yellow_bound = {1'b0, limit} + BW'(YELLOW_SPAN);
  assign cand_w       = {1'b0, cand};

  always_comb begin
    zone = ZONE_OK;
    if (check_en) begin
      if (cand_w < red_bound) begin
        zone = ZONE_RED;
      end else if (cand_w < yellow_bound) begin
        zone = ZONE_YELLOW;
      end
    end
  end
endmodule

// File: rtl/stack_guard_top.sv
module stack_guard_top
  import stack_guard_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int MW = 2,
  parameter int CW = 6,
  parameter logic [AW-1:0] LIMIT_ADDR = 18'h3FFFC,
  parameter int ALIGN_BITS = 8,
  parameter int RED_SPAN = 224,
  parameter int YELLOW_SPAN = 256,
  parameter logic [MW-1:0] KERNEL_MODE = '0,
  parameter logic [DW-1:0] SAFE_SP = 16'h0004,
  parameter logic [DW-1:0] RED_VECTOR = 16'h0004
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_reset,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [MW-1:0] cpu_mode,
  input  logic          sp_upd_valid,
  input  logic [DW-1:0] sp_upd_value,
  input  logic          unwind_valid,
  input  logic [DW-1:0] unwind_pc,
  input  logic [CW-1:0] unwind_count,
  output logic          sp_out_valid,
  output logic [DW-1:0] sp_out,
  output logic          yellow_pulse,
  output logic          red_trap,
  output logic [DW-1:0] trap_vector
);
  logic [DW-1:0] limit;
  logic          cand_valid;
  logic [DW-1:0] cand;
  logic          in_kernel;
  zone_e         zone;

  assign in_kernel = (cpu_mode == KERNEL_MODE);

  stack_guard_limit #(
    .AW(AW), .DW(DW), .LIMIT_ADDR(LIMIT_ADDR), .ALIGN_BITS(ALIGN_BITS)
  ) u_limit (
    .clk(clk), .rst(rst), .bus_reset(bus_reset),
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata),
    .rdata(bus_rdata), .limit(limit)
  );

  stack_guard_source #(.DW(DW), .CW(CW)) u_source (
    .sp_upd_valid(sp_upd_valid), .sp_upd_value(sp_upd_value),
    .unwind_valid(unwind_valid), .unwind_pc(unwind_pc),
    .unwind_count(unwind_count),
    .cand_valid(cand_valid), .cand(cand)
  );

  stack_guard_cmp #(
    .DW(DW), .RED_SPAN(RED_SPAN), .YELLOW_SPAN(YELLOW_SPAN)
  ) u_cmp (
    .check_en(cand_valid && in_kernel), .cand(cand), .limit(limit),
    .zone(zone)
  );

  always_ff @(posedge clk) begin
    if (rst || !cand_valid) begin
      sp_out_valid <= 1'b0;
      sp_out       <= '0;
      yellow_pulse <= 1'b0;
      red_trap     <= 1'b0;
      trap_vector  <= '0;
    end else begin
      sp_out_valid <= 1'b1;
      yellow_pulse <= (zone == ZONE_YELLOW);
      red_trap     <= (zone == ZONE_RED);
      sp_out       <= (zone == ZONE_RED) ? SAFE_SP : cand;
      trap_vector  <= (zone == ZONE_RED) ? RED_VECTOR : '0;
    end
  end

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(yellow_pulse && red_trap));
  a_r7_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    !(sp_upd_valid || unwind_valid) |=> !(yellow_pulse || red_trap || sp_out_valid));
  a_r3_other_mode_quiet: assert property (@(posedge clk) disable iff (rst)
    ((sp_upd_valid || unwind_valid) && !in_kernel) |=> !(yellow_pulse || red_trap));
  a_r4_red_forces: assert property (@(posedge clk) disable iff (rst)
    red_trap |-> (sp_out == SAFE_SP && trap_vector == RED_VECTOR && sp_out_valid));
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!sp_out_valid && !red_trap && !yellow_pulse && bus_rdata == '0));
endmodule

// File: tb/stack_guard_top_bench.sv
`timescale 1ns/1ps
module stack_guard_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_reset = 1'b0;
  logic [17:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  cpu_mode = '0;
  logic        sp_upd_valid = 1'b0;
  logic [15:0] sp_upd_value = '0;
  logic        unwind_valid = 1'b0;
  logic [15:0] unwind_pc = '0;
  logic [5:0]  unwind_count = '0;
  logic        sp_out_valid;
  logic [15:0] sp_out;
  logic        yellow_pulse;
  logic        red_trap;
  logic [15:0] trap_vector;

  localparam logic [17:0] LIM_A = 18'h3FFFC;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int m_lim = 0;
  int e_rdata = 0, e_spv = 0, e_sp = 0, e_yel = 0, e_red = 0, e_vec = 0;

  always #2.5 clk = ~clk;

  stack_guard_top u_stack_guard_top (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_mode(cpu_mode),
    .sp_upd_valid(sp_upd_valid), .sp_upd_value(sp_upd_value),
    .unwind_valid(unwind_valid), .unwind_pc(unwind_pc),
    .unwind_count(unwind_count), .sp_out_valid(sp_out_valid),
    .sp_out(sp_out), .yellow_pulse(yellow_pulse), .red_trap(red_trap),
    .trap_vector(trap_vector)
  );

  // behavioural reference: grading uses the limit before this edge (R11)
  always @(posedge clk) begin
    int c;
    bit v;
    if (rst) begin
      m_lim = 0; e_rdata = 0; e_spv = 0; e_sp = 0; e_yel = 0; e_red = 0; e_vec = 0; // R9
    end else begin
      v = sp_upd_valid || unwind_valid;
      c = unwind_valid ? ((unwind_pc + 2 * unwind_count) % 65536) : sp_upd_value; // R10
      e_spv = v; e_sp = 0; e_yel = 0; e_red = 0; e_vec = 0;
      if (v) begin
        e_sp = c;
        if (cpu_mode == 0 && c < m_lim + 224) begin // R4, R6
          e_red = 1; e_sp = 4; e_vec = 4;
        end else if (cpu_mode == 0 && c < m_lim + 256) begin // R5
          e_yel = 1;
        end
      end
      e_rdata = (bus_rd && bus_addr == LIM_A) ? m_lim : 0; // R1
      if (bus_reset) m_lim = 0; // R8
      else if (bus_wr && bus_addr == LIM_A) m_lim = bus_wdata & 16'hFF00; // R2
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R1 bus_rdata", bus_rdata, e_rdata);
      chk("R7 sp_out_valid", sp_out_valid, e_spv);
      chk("R3/R4/R10 sp_out", sp_out, e_sp);
      chk("R5/R6 yellow_pulse", yellow_pulse, e_yel);
      chk("R4/R7 red_trap", red_trap, e_red);
      chk("R4 trap_vector", trap_vector, e_vec);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step;
    @(negedge clk); #1;
  endtask

  task automatic idle;
    bus_rd = 0; bus_wr = 0; bus_reset = 0; sp_upd_valid = 0; unwind_valid = 0;
  endtask

  task automatic wr_lim(input logic [15:0] d);
    idle(); bus_addr = LIM_A; bus_wr = 1; bus_wdata = d; step(); idle();
  endtask

  task automatic rd_lim;
    idle(); bus_addr = LIM_A; bus_rd = 1; step(); idle(); step();
  endtask

  task automatic upd(input logic [1:0] m, input logic [15:0] v);
    idle(); cpu_mode = m; sp_upd_valid = 1; sp_upd_value = v; step(); idle();
  endtask

  task automatic unw(input logic [15:0] pc, input logic [5:0] n);
    idle(); cpu_mode = 0; unwind_valid = 1; unwind_pc = pc; unwind_count = n;
    step(); idle();
  endtask

  initial begin
    step(); step();
    rst = 0; step();                 // R9 reset state compared here
    rd_lim();                        // R1 reads 0 after reset
    wr_lim(16'h12AB); rd_lim();      // R2 low byte dropped -> 0x1200
    idle(); bus_addr = 18'h3FFFA; bus_wr = 1; bus_wdata = 16'h7700; step(); idle();
    rd_lim();                        // R2 other address ignored
    idle(); bus_addr = 18'h3FFFA; bus_rd = 1; step(); idle(); step(); // R1 other addr -> 0
    upd(0, 16'h12DF); upd(0, 16'h12E0); upd(0, 16'h12FF); upd(0, 16'h1300); // R4/R5 edges
    upd(0, 16'h0000);                // R4
    upd(1, 16'h0000); upd(3, 16'h12E5); // R3
    wr_lim(16'hFFFF);
    upd(0, 16'hFFFF); upd(0, 16'hFFDF); upd(0, 16'hFFE0); upd(0, 16'h0100); // R6
    wr_lim(16'h2000);
    unw(16'h2000, 6'd0); unw(16'h2000, 6'd63); unw(16'h2100, 6'd5); unw(16'hFFF0, 6'd63); // R10
    idle(); cpu_mode = 0; sp_upd_valid = 1; sp_upd_value = 16'h0000;
    unwind_valid = 1; unwind_pc = 16'h2100; unwind_count = 6'd3; step(); idle(); // R10 priority
    // R11: write raises limit in same cycle as update
    idle(); bus_addr = LIM_A; bus_wr = 1; bus_wdata = 16'h8000;
    sp_upd_valid = 1; sp_upd_value = 16'h2100; step(); idle();
    upd(0, 16'h2100);
    // R8: bus reset wins over write
    idle(); bus_reset = 1; bus_addr = LIM_A; bus_wr = 1; bus_wdata = 16'h4400; step(); idle();
    rd_lim(); upd(0, 16'h0010); upd(0, 16'h00F0);
    // random traffic, R7 strobeless cycles included
    for (int i = 0; i < 400; i++) begin
      idle();
      bus_addr = ($urandom % 4 == 0) ? 18'h3FFF8 : LIM_A;
      bus_rd = $urandom % 3 == 0;
      bus_wr = $urandom % 5 == 0;
      bus_wdata = $urandom;
      bus_reset = $urandom % 40 == 0;
      cpu_mode = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
      sp_upd_valid = $urandom % 2 == 0;
      sp_upd_value = ($urandom % 2) ? 16'($urandom) : 16'(m_lim + ($urandom % 300));
      unwind_valid = $urandom % 6 == 0;
      unwind_pc = $urandom; unwind_count = $urandom;
      step();
    end
    idle(); wr_lim(16'h5500);
    rst = 1; step(); rst = 0; step(); rd_lim(); // R9 clears limit
    step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule